// File: doc/BRIEF.md
# Dual-Channel Lock Queue Unit

This unit sits in every node of a many-core chip and owns a small set of lock variables. Any core can reach any of them through a global lock number. Requests arrive on two ports that are served in the same cycle. One port carries traffic from the core in the same node. The other carries requests that came in from other nodes over the on-chip network; the transport itself lives outside this block. Each request is either an acquire or a release, and it names a lock and the requesting node.

A request for a lock that is free is granted at once. A request for a lock that is held is parked in a wait list for that lock. All lists draw their entries from one shared pool, and the entries are linked together with next-pointers. Because every lock has its own list, a waiter on one lock never stalls traffic aimed at another lock. When the owner releases a lock that has waiters, ownership passes straight to the oldest waiter. A hand-off notice naming the lock and the new owner is raised on the channel that carried the release, and the pool entry returns to the free set. A release from anyone other than the owner is rejected and has no effect.

Top module: `lockq_sync`

## Requirements
- R1: After reset no response or hand-off is raised, no lock is held, and both ready outputs are high.
- R2: An accepted acquire (op 0) for a lock that is not held returns response code 0 (granted) on the next cycle. The lock's bit in `lock_held` is set and the requester becomes the owner.
- R3: An accepted acquire for a held lock returns code 1 (queued) on the next cycle and uses one pool entry.
- R4: An accepted release (op 1) by the owner of a lock with no waiters returns code 2 (released) and clears the lock's `lock_held` bit.
- R5: A release by the owner of a lock with waiters returns code 2. In the same cycle, that channel raises a hand-off naming the lock and the oldest waiter, and that waiter becomes the owner. Waiters are served in arrival order.
- R6: A release by a node that is not the owner, or a release of a lock that is not held, returns code 3 (error). It leaves the owner and the wait list unchanged.
- R7: Both channels are served in the same cycle with separate responses. A waiter on one lock does not delay grants of other locks.
- R8: When both channels are accepted in one cycle, the local channel's request takes effect first. The network request sees its result, even when both name the same lock.
- R9: When every pool entry is in use, an acquire for a held lock sees its channel's ready low and gets no response. Releases and acquires of free locks stay ready. An entry freed by a local release can be used by a network acquire in the same cycle.
- R10: Every accepted request gets exactly one response, one cycle after acceptance, and a channel with no accepted request raises no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lc_valid | input | 1 | Local channel request present |
| lc_ready | output | 1 | Local channel can accept the current request |
| lc_op | input | 1 | Local op: 0 acquire, 1 release |
| lc_lock | input | LOCK_W | Local target lock |
| lc_node | input | NODE_W | Local requester identity |
| nw_valid | input | 1 | Network channel request present |
| nw_ready | output | 1 | Network channel can accept the current request |
| nw_op | input | 1 | Network op: 0 acquire, 1 release |
| nw_lock | input | LOCK_W | Network target lock |
| nw_node | input | NODE_W | Network requester identity |
| lc_rsp_valid | output | 1 | Local response present |
| lc_rsp_code | output | 2 | Local response: 0 granted, 1 queued, 2 released, 3 error |
| nw_rsp_valid | output | 1 | Network response present |
| nw_rsp_code | output | 2 | Network response code, same encoding |
| lc_ho_valid | output | 1 | Hand-off caused by a local release |
| lc_ho_lock | output | LOCK_W | Lock handed off by the local release |
| lc_ho_node | output | NODE_W | New owner after the local release |
| nw_ho_valid | output | 1 | Hand-off caused by a network release |
| nw_ho_lock | output | LOCK_W | Lock handed off by the network release |
| nw_ho_node | output | NODE_W | New owner after the network release |
| lock_held | output | NUM_LOCKS | One bit per lock, set while owned |

## Verification
The bench builds the unit with four locks, four pool entries and four-bit node identities. With a pool that small, a handful of waiters spread over several locks is enough to fill it. That brings the back-pressure path within reach, and so is the case where a local release frees an entry that the network acquire claims in the same cycle. Four locks are still enough to hold one lock with a waiter while others are granted, and to drive both channels at one lock in the same cycle.

// File: rtl/lockq_pkg.sv
package lockq_pkg;

  typedef enum logic {
    OP_ACQ = 1'b0,
    OP_REL = 1'b1
  } lq_op_e;

  typedef enum logic [1:0] {
    RSP_GRANTED  = 2'd0,
    RSP_QUEUED   = 2'd1,
    RSP_RELEASED = 2'd2,
    RSP_ERROR    = 2'd3
  } lq_rsp_e;

endpackage

// File: rtl/lockq_freepick.sv
// Picks the lowest-numbered pool entry that is not in use.
module lockq_freepick #(
  parameter int NP = 16,
  parameter int PW = $clog2(NP)
) (
  input  logic [NP-1:0] busy,
  output logic [PW-1:0] idx,
  output logic          any
);

  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = NP - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        idx = PW'(i);
        any = 1'b1;
      end
    end
  end

endmodule

// File: rtl/lockq_step.sv
// Applies one channel's request to the lock and queue state, combinationally.
module lockq_step
  import lockq_pkg::*;
#(
  parameter int NL = 8,
  parameter int NP = 16,
  parameter int NW = 4,
  parameter int LW = $clog2(NL),
  parameter int PW = $clog2(NP)
) (
  input  logic                    valid,
  input  logic                    op,
  input  logic [LW-1:0]           lock,
  input  logic [NW-1:0]           node,
  input  logic [NL-1:0]           held_i,
  input  logic [NL-1:0][NW-1:0]   owner_i,
  input  logic [NL-1:0]           qne_i,
  input  logic [NL-1:0][PW-1:0]   head_i,
  input  logic [NL-1:0][PW-1:0]   tail_i,
  input  logic [NP-1:0][PW-1:0]   nxt_i,
  input  logic [NP-1:0][NW-1:0]   who_i,
  input  logic [NP-1:0]           busy_i,
  output logic [NL-1:0]           held_o,
  output logic [NL-1:0][NW-1:0]   owner_o,
  output logic [NL-1:0]           qne_o,
  output logic [NL-1:0][PW-1:0]   head_o,
  output logic [NL-1:0][PW-1:0]   tail_o,
  output logic [NP-1:0][PW-1:0]   nxt_o,
  output logic [NP-1:0][NW-1:0]   who_o,
  output logic [NP-1:0]           busy_o,
  output logic                    ready,
  output logic                    fire,
  output logic [1:0]              code,
  output logic                    ho_valid,
  output logic [NW-1:0]           ho_node
);

  logic [PW-1:0] slot;
  logic          slot_ok;
  logic [PW-1:0] h;
  lq_rsp_e       rsp;

  // A release is legal only from the node that holds the lock.
  function automatic logic release_ok(input logic is_held, input logic [NW-1:0] own,
                                      input logic [NW-1:0] who);
    return is_held && (own == who);
  endfunction

  // An acquire must wait for pool space only when it would have to queue.
  function automatic logic needs_slot(input logic o, input logic is_held);
    return (o == OP_ACQ) && is_held;
  endfunction

  lockq_freepick #(.NP(NP), .PW(PW)) u_pick (
    .busy (busy_i),
    .idx  (slot),
    .any  (slot_ok)
  );

  always_comb begin
    held_o   = held_i;
    owner_o  = owner_i;
    qne_o    = qne_i;
    head_o   = head_i;
    tail_o   = tail_i;
    nxt_o    = nxt_i;
    who_o    = who_i;
    busy_o   = busy_i;
    rsp      = RSP_GRANTED;
    ho_valid = 1'b0;
    ho_node  = '0;
    h        = head_i[lock];
    ready    = !(needs_slot(op, held_i[lock]) && !slot_ok);
    fire     = valid && ready;
    if (fire) begin
      if (op == OP_ACQ) begin
        if (!held_i[lock]) begin
          held_o[lock]  = 1'b1;
          owner_o[lock] = node;
          rsp           = RSP_GRANTED;
        end else begin
          busy_o[slot] = 1'b1;
          who_o[slot]  = node;
          nxt_o[slot]  = slot;
          if (!qne_i[lock]) begin
            head_o[lock] = slot;
            qne_o[lock]  = 1'b1;
          end else begin
            nxt_o[tail_i[lock]] = slot;
          end
          tail_o[lock] = slot;
          rsp          = RSP_QUEUED;
        end
      end else if (!release_ok(held_i[lock], owner_i[lock], node)) begin
        rsp = RSP_ERROR;
      end else begin
        rsp = RSP_RELEASED;
        if (!qne_i[lock]) begin
          held_o[lock] = 1'b0;
        end else begin
          owner_o[lock] = who_i[h];
          ho_valid      = 1'b1;
          ho_node       = who_i[h];
          busy_o[h]     = 1'b0;
          if (h == tail_i[lock]) qne_o[lock] = 1'b0;
          else                   head_o[lock] = nxt_i[h];
        end
      end
    end
    code = rsp;
  end

endmodule

// File: rtl/lockq_sync.sv
// Per-node lock unit: two request channels, per-lock wait lists in a shared pool.
module lockq_sync
  import lockq_pkg::*;
#(
  parameter int NUM_LOCKS  = 8,
  parameter int POOL_DEPTH = 16,
  parameter int NODE_W     = 4,
  parameter int LOCK_W     = $clog2(NUM_LOCKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lc_valid,
  output logic                 lc_ready,
  input  logic                 lc_op,
  input  logic [LOCK_W-1:0]    lc_lock,
  input  logic [NODE_W-1:0]    lc_node,
  input  logic                 nw_valid,
  output logic                 nw_ready,
  input  logic                 nw_op,
  input  logic [LOCK_W-1:0]    nw_lock,
  input  logic [NODE_W-1:0]    nw_node,
  output logic                 lc_rsp_valid,
  output logic [1:0]           lc_rsp_code,
  output logic                 nw_rsp_valid,
  output logic [1:0]           nw_rsp_code,
  output logic                 lc_ho_valid,
  output logic [LOCK_W-1:0]    lc_ho_lock,
  output logic [NODE_W-1:0]    lc_ho_node,
  output logic                 nw_ho_valid,
  output logic [LOCK_W-1:0]    nw_ho_lock,
  output logic [NODE_W-1:0]    nw_ho_node,
  output logic [NUM_LOCKS-1:0] lock_held
);

  localparam int NL  = NUM_LOCKS;
  localparam int NP  = POOL_DEPTH;
  localparam int NW  = NODE_W;
  localparam int PW  = $clog2(NP);
  localparam int NCH = 2;   // channel 0 = local (applied first), 1 = network

  // Stage 0 is the registered state; stage NCH is the next state.
  logic [NL-1:0]           st_held  [NCH+1];
  logic [NL-1:0][NW-1:0]   st_owner [NCH+1];
  logic [NL-1:0]           st_qne   [NCH+1];
  logic [NL-1:0][PW-1:0]   st_head  [NCH+1];
  logic [NL-1:0][PW-1:0]   st_tail  [NCH+1];
  logic [NP-1:0][PW-1:0]   st_nxt   [NCH+1];
  logic [NP-1:0][NW-1:0]   st_who   [NCH+1];
  logic [NP-1:0]           st_busy  [NCH+1];

  logic                    ch_valid [NCH];
  logic                    ch_op    [NCH];
  logic [LOCK_W-1:0]       ch_lock  [NCH];
  logic [NW-1:0]           ch_node  [NCH];
  logic                    ch_ready [NCH];
  logic                    ch_fire  [NCH];
  logic [1:0]              ch_code  [NCH];
  logic                    ch_ho    [NCH];
  logic [NW-1:0]           ch_hon   [NCH];

  logic                    r_rsp_v  [NCH];
  logic [1:0]              r_rsp_c  [NCH];
  logic                    r_ho_v   [NCH];
  logic [LOCK_W-1:0]       r_ho_l   [NCH];
  logic [NW-1:0]           r_ho_n   [NCH];

  // Named internal events for the checker.
  logic pool_full;
  logic lc_fire;
  logic nw_fire;

  assign ch_valid[0] = lc_valid;
  assign ch_op[0]    = lc_op;
  assign ch_lock[0]  = lc_lock;
  assign ch_node[0]  = lc_node;
  assign ch_valid[1] = nw_valid;
  assign ch_op[1]    = nw_op;
  assign ch_lock[1]  = nw_lock;
  assign ch_node[1]  = nw_node;

  generate
    for (genvar s = 0; s < NCH; s++) begin : g_stage
      lockq_step #(.NL(NL), .NP(NP), .NW(NW), .LW(LOCK_W), .PW(PW)) u_step (
        .valid    (ch_valid[s]),
        .op       (ch_op[s]),
        .lock     (ch_lock[s]),
        .node     (ch_node[s]),
        .held_i   (st_held[s]),
        .owner_i  (st_owner[s]),
        .qne_i    (st_qne[s]),
        .head_i   (st_head[s]),
        .tail_i   (st_tail[s]),
        .nxt_i    (st_nxt[s]),
        .who_i    (st_who[s]),
        .busy_i   (st_busy[s]),
        .held_o   (st_held[s+1]),
        .owner_o  (st_owner[s+1]),
        .qne_o    (st_qne[s+1]),
        .head_o   (st_head[s+1]),
        .tail_o   (st_tail[s+1]),
        .nxt_o    (st_nxt[s+1]),
        .who_o    (st_who[s+1]),
        .busy_o   (st_busy[s+1]),
        .ready    (ch_ready[s]),
        .fire     (ch_fire[s]),
        .code     (ch_code[s]),
        .ho_valid (ch_ho[s]),
        .ho_node  (ch_hon[s])
      );

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          r_rsp_v[s] <= 1'b0;
          r_rsp_c[s] <= '0;
          r_ho_v[s]  <= 1'b0;
          r_ho_l[s]  <= '0;
          r_ho_n[s]  <= '0;
        end else begin
          r_rsp_v[s] <= ch_fire[s];
          r_rsp_c[s] <= ch_code[s];
          r_ho_v[s]  <= ch_ho[s];
          r_ho_l[s]  <= ch_lock[s];
          r_ho_n[s]  <= ch_hon[s];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_held[0]  <= '0;
      st_owner[0] <= '0;
      st_qne[0]   <= '0;
      st_head[0]  <= '0;
      st_tail[0]  <= '0;
      st_nxt[0]   <= '0;
      st_who[0]   <= '0;
      st_busy[0]  <= '0;
    end else begin
      st_held[0]  <= st_held[NCH];
      st_owner[0] <= st_owner[NCH];
      st_qne[0]   <= st_qne[NCH];
      st_head[0]  <= st_head[NCH];
      st_tail[0]  <= st_tail[NCH];
      st_nxt[0]   <= st_nxt[NCH];
      st_who[0]   <= st_who[NCH];
      st_busy[0]  <= st_busy[NCH];
    end
  end

  assign pool_full    = &st_busy[0];
  assign lc_fire      = ch_fire[0];
  assign nw_fire      = ch_fire[1];

  assign lc_ready     = ch_ready[0];
  assign nw_ready     = ch_ready[1];
  assign lc_rsp_valid = r_rsp_v[0];
  assign lc_rsp_code  = r_rsp_c[0];
  assign nw_rsp_valid = r_rsp_v[1];
  assign nw_rsp_code  = r_rsp_c[1];
  assign lc_ho_valid  = r_ho_v[0];
  assign lc_ho_lock   = r_ho_l[0];
  assign lc_ho_node   = r_ho_n[0];
  assign nw_ho_valid  = r_ho_v[1];
  assign nw_ho_lock   = r_ho_l[1];
  assign nw_ho_node   = r_ho_n[1];
  assign lock_held    = st_held[0];

endmodule

// File: rtl/lockq_sync_chk.sv
module lockq_sync_chk #(
  parameter int NUM_LOCKS = 8,
  parameter int NODE_W    = 4,
  parameter int LOCK_W    = $clog2(NUM_LOCKS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 lc_valid,
  input logic                 lc_ready,
  input logic                 lc_op,
  input logic [LOCK_W-1:0]    lc_lock,
  input logic                 nw_valid,
  input logic                 nw_ready,
  input logic                 nw_op,
  input logic                 lc_rsp_valid,
  input logic [1:0]           lc_rsp_code,
  input logic                 nw_rsp_valid,
  input logic                 lc_ho_valid,
  input logic                 nw_ho_valid,
  input logic [LOCK_W-1:0]    nw_ho_lock,
  input logic [NUM_LOCKS-1:0] lock_held,
  input logic                 pool_full,
  input logic                 lc_fire,
  input logic                 nw_fire
);

  // R2: a local acquire of a lock not held is granted on the next cycle
  p_free_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lc_valid && lc_ready && !lc_op && !lock_held[lc_lock]) |=> (lc_rsp_valid && lc_rsp_code == 2'd0));

  // R5: a hand-off leaves the lock owned
  p_handoff_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    nw_ho_valid |-> lock_held[nw_ho_lock]);

  // R5: a hand-off comes only with a successful release response
  p_handoff_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lc_ho_valid |-> (lc_rsp_valid && lc_rsp_code == 2'd2));

  // R6: releasing a lock that nobody holds is an error
  p_free_release_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lc_valid && lc_op && !lock_held[lc_lock]) |=> (lc_rsp_valid && lc_rsp_code == 2'd3));

  // R9: a full pool stalls an acquire of a held lock
  p_full_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pool_full && !lc_op && lock_held[lc_lock]) |-> !lc_ready);

  // R9: releases are never stalled
  p_release_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nw_op |-> nw_ready);

  // R10: one response per accepted request, none otherwise
  p_lc_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lc_fire |=> lc_rsp_valid);
  p_lc_norsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !lc_fire |=> !lc_rsp_valid);
  p_nw_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    nw_fire |=> nw_rsp_valid);
  p_nw_norsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!nw_valid || !nw_ready) |=> !nw_rsp_valid);

endmodule

bind lockq_sync lockq_sync_chk #(
  .NUM_LOCKS (NUM_LOCKS),
  .NODE_W    (NODE_W),
  .LOCK_W    (LOCK_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lc_valid     (lc_valid),
  .lc_ready     (lc_ready),
  .lc_op        (lc_op),
  .lc_lock      (lc_lock),
  .nw_valid     (nw_valid),
  .nw_ready     (nw_ready),
  .nw_op        (nw_op),
  .lc_rsp_valid (lc_rsp_valid),
  .lc_rsp_code  (lc_rsp_code),
  .nw_rsp_valid (nw_rsp_valid),
  .lc_ho_valid  (lc_ho_valid),
  .nw_ho_valid  (nw_ho_valid),
  .nw_ho_lock   (nw_ho_lock),
  .lock_held    (lock_held),
  .pool_full    (pool_full),
  .lc_fire      (lc_fire),
  .nw_fire      (nw_fire)
);

// File: tb/sim_lockq_sync.sv
`timescale 1ns/100ps
module sim_lockq_sync;

  localparam int NL = 4;
  localparam int NP = 4;
  localparam int NW = 4;
  localparam int LW = $clog2(NL);
  localparam int ACQ = 0, REL = 1;
  localparam int GRANTED = 0, QUEUED = 1, RELEASED = 2, ERROR = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lc_valid = 1'b0, lc_op = 1'b0, nw_valid = 1'b0, nw_op = 1'b0;
  logic [LW-1:0] lc_lock = '0, nw_lock = '0;
  logic [NW-1:0] lc_node = '0, nw_node = '0;
  logic lc_ready, nw_ready, lc_rsp_valid, nw_rsp_valid, lc_ho_valid, nw_ho_valid;
  logic [1:0] lc_rsp_code, nw_rsp_code;
  logic [LW-1:0] lc_ho_lock, nw_ho_lock;
  logic [NW-1:0] lc_ho_node, nw_ho_node;
  logic [NL-1:0] lock_held;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic lr, nr;

  always #2.5 clk = ~clk;

  lockq_sync #(.NUM_LOCKS(NL), .POOL_DEPTH(NP), .NODE_W(NW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .lc_valid(lc_valid), .lc_ready(lc_ready), .lc_op(lc_op), .lc_lock(lc_lock), .lc_node(lc_node),
    .nw_valid(nw_valid), .nw_ready(nw_ready), .nw_op(nw_op), .nw_lock(nw_lock), .nw_node(nw_node),
    .lc_rsp_valid(lc_rsp_valid), .lc_rsp_code(lc_rsp_code),
    .nw_rsp_valid(nw_rsp_valid), .nw_rsp_code(nw_rsp_code),
    .lc_ho_valid(lc_ho_valid), .lc_ho_lock(lc_ho_lock), .lc_ho_node(lc_ho_node),
    .nw_ho_valid(nw_ho_valid), .nw_ho_lock(nw_ho_lock), .nw_ho_node(nw_ho_node),
    .lock_held(lock_held)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One cycle of stimulus; returns at the next falling edge with responses visible.
  task automatic cyc(input bit lv, input int lo, input int ll, input int ln,
                     input bit nv, input int no, input int nl, input int nn);
    lc_valid = lv; lc_op = lo[0]; lc_lock = LW'(ll); lc_node = NW'(ln);
    nw_valid = nv; nw_op = no[0]; nw_lock = LW'(nl); nw_node = NW'(nn);
    #1;
    lr = lc_ready;
    nr = nw_ready;
    @(posedge clk);
    #1;
    lc_valid = 1'b0;
    nw_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic lc_only(input int o, input int l, input int n);
    cyc(1, o, l, n, 0, 0, 0, 0);
  endtask

  task automatic nw_only(input int o, input int l, input int n);
    cyc(0, 0, 0, 0, 1, o, l, n);
  endtask

  task automatic t_reset;
    chk("R1", "lock_held", int'(lock_held), 0);
    chk("R1", "lc_rsp_valid", int'(lc_rsp_valid), 0);
    chk("R1", "nw_rsp_valid", int'(nw_rsp_valid), 0);
    chk("R1", "handoffs", int'(lc_ho_valid) + int'(nw_ho_valid), 0);
    chk("R1", "lc_ready", int'(lc_ready), 1);
    chk("R1", "nw_ready", int'(nw_ready), 1);
  endtask

  task automatic t_grant;
    lc_only(ACQ, 0, 1);
    chk("R2", "lc code", int'(lc_rsp_code), GRANTED);
    chk("R2", "lc rsp valid", int'(lc_rsp_valid), 1);
    chk("R2", "held bit 0", int'(lock_held[0]), 1);
    chk("R10", "nw idle no rsp", int'(nw_rsp_valid), 0);
  endtask

  task automatic t_queue;
    nw_only(ACQ, 0, 2);
    chk("R3", "nw code n2", int'(nw_rsp_code), QUEUED);
    chk("R10", "lc idle no rsp", int'(lc_rsp_valid), 0);
    nw_only(ACQ, 0, 3);
    chk("R3", "nw code n3", int'(nw_rsp_code), QUEUED);
  endtask

  task automatic t_bad_release;
    nw_only(REL, 0, 2);
    chk("R6", "non-owner code", int'(nw_rsp_code), ERROR);
    chk("R6", "non-owner no handoff", int'(nw_ho_valid), 0);
    chk("R6", "lock 0 still held", int'(lock_held[0]), 1);
    lc_only(REL, 1, 1);
    chk("R6", "free lock release code", int'(lc_rsp_code), ERROR);
    chk("R6", "lock 1 still free", int'(lock_held[1]), 0);
  endtask

  task automatic t_handoff;
    lc_only(REL, 0, 1);
    chk("R5", "release code", int'(lc_rsp_code), RELEASED);
    chk("R5", "ho valid", int'(lc_ho_valid), 1);
    chk("R5", "ho lock", int'(lc_ho_lock), 0);
    chk("R5", "ho node first waiter", int'(lc_ho_node), 2);
    chk("R5", "lock 0 held", int'(lock_held[0]), 1);
    nw_only(REL, 0, 2);
    chk("R5", "second release code", int'(nw_rsp_code), RELEASED);
    chk("R5", "ho node second waiter", int'(nw_ho_node), 3);
    chk("R5", "nw ho valid", int'(nw_ho_valid), 1);
    nw_only(REL, 0, 3);
    chk("R4", "last release code", int'(nw_rsp_code), RELEASED);
    chk("R4", "no handoff", int'(nw_ho_valid), 0);
    chk("R4", "lock 0 free", int'(lock_held[0]), 0);
  endtask

  task automatic t_no_hol;
    lc_only(ACQ, 1, 1);
    chk("R7", "lock1 grant", int'(lc_rsp_code), GRANTED);
    nw_only(ACQ, 1, 5);
    chk("R7", "lock1 waiter queued", int'(nw_rsp_code), QUEUED);
    cyc(1, ACQ, 2, 6, 1, ACQ, 3, 8);
    chk("R7", "lc lock2 grant", int'(lc_rsp_code), GRANTED);
    chk("R7", "nw lock3 grant", int'(nw_rsp_code), GRANTED);
    chk("R7", "both responded", int'(lc_rsp_valid) + int'(nw_rsp_valid), 2);
    chk("R7", "held map", int'(lock_held), 14);
  endtask

  task automatic t_same_cycle;
    cyc(1, ACQ, 0, 9, 1, ACQ, 0, 10);
    chk("R8", "local wins grant", int'(lc_rsp_code), GRANTED);
    chk("R8", "network queued", int'(nw_rsp_code), QUEUED);
    lc_only(REL, 0, 9);
    chk("R8", "owner was local n9, ho to n10", int'(lc_ho_node), 10);
    cyc(1, REL, 0, 10, 1, ACQ, 0, 11);
    chk("R8", "local release first", int'(lc_rsp_code), RELEASED);
    chk("R8", "network grant after release", int'(nw_rsp_code), GRANTED);
    chk("R8", "lock 0 held", int'(lock_held[0]), 1);
  endtask

  task automatic t_pool_full;
    lc_only(ACQ, 2, 12);
    chk("R3", "fill L2", int'(lc_rsp_code), QUEUED);
    lc_only(ACQ, 3, 13);
    chk("R3", "fill L3", int'(lc_rsp_code), QUEUED);
    lc_only(ACQ, 0, 14);
    chk("R3", "fill L0", int'(lc_rsp_code), QUEUED);
    cyc(1, ACQ, 1, 15, 1, ACQ, 2, 15);
    chk("R9", "lc ready when full", int'(lr), 0);
    chk("R9", "nw ready when full", int'(nr), 0);
    chk("R9", "no lc rsp", int'(lc_rsp_valid), 0);
    chk("R9", "no nw rsp", int'(nw_rsp_valid), 0);
    cyc(1, REL, 3, 8, 1, ACQ, 2, 15);
    chk("R9", "release ready when full", int'(lr), 1);
    chk("R9", "freed entry reused same cycle", int'(nr), 1);
    chk("R9", "nw queued", int'(nw_rsp_code), QUEUED);
    chk("R5", "L3 ho n13", int'(lc_ho_node), 13);
    lc_only(REL, 2, 6);
    chk("R5", "L2 first waiter n12", int'(lc_ho_node), 12);
    lc_only(REL, 2, 12);
    chk("R5", "L2 next waiter n15", int'(lc_ho_node), 15);
    lc_only(REL, 1, 1);
    chk("R5", "L1 waiter n5", int'(lc_ho_node), 5);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_grant();
    t_queue();
    t_bad_release();
    t_handoff();
    t_no_hol();
    t_same_cycle();
    t_pool_full();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(5 * 200000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule